// File: doc/BRIEF.md
# DMA Transfer Parameter Shadow Bank

This block holds the five 32-bit parameters that describe one DMA transfer: options, source address, count, destination address and index. The parameters can only be written. Each one answers at two addresses. A store to the plain address only updates the register. A store to the submit address updates the same register and also launches a transfer request.

The request carries a snapshot of all five parameters, and that snapshot already holds the value being written in that store. Software therefore loads four parameters with ordinary stores and finishes with one store to a submit address. The block accepts a write on every clock cycle. The only exception is a submit store that arrives while an earlier request is still waiting for the engine. That store is held with `wr_ready` low until the engine takes the pending request.

The count parameter packs the line/frame count in bits 31:16 and the element count in bits 15:0. The block passes it through unchanged. The engine that moves the data is outside this block.

Top module: `dma_param_shadow`

## Requirements
- R1: While `rst` is high and after it falls, `req_valid` is 0, `wr_ready` is 1 and all five parameters are zero. A first submit therefore reports zero for every parameter it did not write.
- R2: The parameters sit at byte addresses base 0x0200_0000 + 0x00 (options), +0x04 (source), +0x08 (count), +0x0C (destination) and +0x10 (index). They appear on `req_opt`, `req_src`, `req_cnt`, `req_dst` and `req_idx`.
- R3: An accepted write to a plain address stores `wr_data` in the selected parameter and does not raise `req_valid`.
- R4: An accepted write to a submit address stores the value and raises `req_valid` on the next cycle. The snapshot on the request outputs includes the value just written.
- R5: `wr_be` has no effect. Every accepted write replaces all 32 bits of the parameter.
- R6: Writes outside the ten mapped words are ignored. This covers offsets 0x14–0x1C and 0x34–0x3C as well as addresses outside the 64-byte window.
- R7: While `req_valid` is 1 and `req_ready` is 0, the request and its payload stay unchanged, even when plain writes change the parameters. After an accept cycle with no new submit, `req_valid` falls.
- R8: A submit write that arrives while a request is pending and not accepted sees `wr_ready` at 0 in that same cycle. It is applied once the pending request is accepted, and it is never dropped. Plain writes keep `wr_ready` at 1 during that time.
- R9: While `req_ready` is 1, submit writes on consecutive cycles produce a request on every cycle, and each request carries the cumulative parameter set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 32 | Byte address of the write |
| wr_data | input | 32 | Write data |
| wr_be | input | 4 | Byte enables (ignored) |
| wr_ready | output | 1 | Write accepted this cycle when high |
| req_valid | output | 1 | Transfer request pending |
| req_ready | input | 1 | Engine accepts the request |
| req_opt | output | 32 | Options snapshot |
| req_src | output | 32 | Source snapshot |
| req_cnt | output | 32 | Count snapshot |
| req_dst | output | 32 | Destination snapshot |
| req_idx | output | 32 | Index snapshot |

## Verification
The assertions take three things for granted about the inputs:
- The engine drives `req_ready` as a plain level.
- A writer that sees `wr_ready` low holds its address and data until the store is taken.
- `wr_en` is never X outside reset.

The stimulus meets these assumptions by changing every input only on the falling clock edge. It also keeps a stalled submit store fixed until the bench raises `req_ready`. The address sweep covers every word offset in the window and two addresses outside it.

// File: rtl/dps_pkg.sv
package dps_pkg;
  localparam int NUM_PARAMS = 5;
  localparam int SLOT_OPT = 0;
  localparam int SLOT_SRC = 1;
  localparam int SLOT_CNT = 2;
  localparam int SLOT_DST = 3;
  localparam int SLOT_IDX = 4;
endpackage

// File: rtl/dps_addr_decode.sv
module dps_addr_decode #(
  parameter int          ADDR_W     = 32,
  parameter logic [31:0] BASE_ADDR  = 32'h0200_0000,
  parameter int          ALIAS_BIT  = 5,
  parameter int          NUM_SLOTS  = 5,
  localparam int         SLOT_W     = ALIAS_BIT - 2
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic              is_alias,
  output logic [SLOT_W-1:0] slot
);
  localparam int WIN_LSB = ALIAS_BIT + 1;

  logic in_window;
  logic addr_lsb_unused;

  assign addr_lsb_unused = ^addr[1:0];
  assign in_window = (addr[ADDR_W-1:WIN_LSB] == BASE_ADDR[ADDR_W-1:WIN_LSB]);
  assign slot      = addr[ALIAS_BIT-1:2];
  assign is_alias  = addr[ALIAS_BIT];
  assign hit       = in_window && (int'(slot) < NUM_SLOTS);
endmodule

// File: rtl/dps_param_bank.sv
module dps_param_bank #(
  parameter int DATA_W    = 32,
  parameter int NUM_SLOTS = 5,
  parameter int SLOT_W    = 3
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               we,
  input  logic [SLOT_W-1:0]                  wslot,
  input  logic [DATA_W-1:0]                  wdata,
  output logic [NUM_SLOTS-1:0][DATA_W-1:0]   snap
);
  logic [NUM_SLOTS-1:0][DATA_W-1:0] regs;

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
    logic sel;
    assign sel = we && (int'(wslot) == k);

    always_ff @(posedge clk) begin
      if (rst)      regs[k] <= '0;
      else if (sel) regs[k] <= wdata;
    end

    // Same-cycle bypass so a submit sees its own value
    assign snap[k] = sel ? wdata : regs[k];
  end
endmodule

// File: rtl/dps_req_launch.sv
module dps_req_launch #(
  parameter int DATA_W    = 32,
  parameter int NUM_SLOTS = 5
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             submit,
  input  logic [NUM_SLOTS-1:0][DATA_W-1:0] snap,
  input  logic                             req_ready,
  output logic                             req_valid,
  output logic [NUM_SLOTS-1:0][DATA_W-1:0] req_bus,
  output logic                             blocked
);
  assign blocked = req_valid && !req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_valid <= 1'b0;
      req_bus   <= '0;
    end else if (submit) begin
      req_valid <= 1'b1;
      req_bus   <= snap;
    end else if (req_ready) begin
      req_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/dma_param_shadow.sv
module dma_param_shadow #(
  parameter int          DATA_W    = 32,
  parameter int          ADDR_W    = 32,
  parameter int          BE_W      = DATA_W / 8,
  parameter logic [31:0] BASE_ADDR = 32'h0200_0000,
  parameter int          ALIAS_BIT = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [BE_W-1:0]   wr_be,
  output logic              wr_ready,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [DATA_W-1:0] req_opt,
  output logic [DATA_W-1:0] req_src,
  output logic [DATA_W-1:0] req_cnt,
  output logic [DATA_W-1:0] req_dst,
  output logic [DATA_W-1:0] req_idx
);
  import dps_pkg::*;

  localparam int SLOT_W = ALIAS_BIT - 2;

  logic              dec_hit;
  logic              dec_alias;
  logic [SLOT_W-1:0] dec_slot;
  logic              blocked;
  logic              wr_take;
  logic              submit;
  logic              be_unused;
  logic [NUM_PARAMS-1:0][DATA_W-1:0] snap;
  logic [NUM_PARAMS-1:0][DATA_W-1:0] req_bus;

  // Byte enables are ignored: every write replaces the whole word
  assign be_unused = ^wr_be;

  dps_addr_decode #(
    .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR),
    .ALIAS_BIT(ALIAS_BIT), .NUM_SLOTS(NUM_PARAMS)
  ) u_dec (
    .addr(wr_addr), .hit(dec_hit), .is_alias(dec_alias), .slot(dec_slot)
  );

  assign wr_ready = !(dec_hit && dec_alias && blocked);
  assign wr_take  = wr_en && dec_hit && wr_ready;
  assign submit   = wr_take && dec_alias;

  dps_param_bank #(
    .DATA_W(DATA_W), .NUM_SLOTS(NUM_PARAMS), .SLOT_W(SLOT_W)
  ) u_bank (
    .clk(clk), .rst(rst), .we(wr_take), .wslot(dec_slot),
    .wdata(wr_data), .snap(snap)
  );

  dps_req_launch #(
    .DATA_W(DATA_W), .NUM_SLOTS(NUM_PARAMS)
  ) u_launch (
    .clk(clk), .rst(rst), .submit(submit), .snap(snap),
    .req_ready(req_ready), .req_valid(req_valid),
    .req_bus(req_bus), .blocked(blocked)
  );

  assign req_opt = req_bus[SLOT_OPT];
  assign req_src = req_bus[SLOT_SRC];
  assign req_cnt = req_bus[SLOT_CNT];
  assign req_dst = req_bus[SLOT_DST];
  assign req_idx = req_bus[SLOT_IDX];
endmodule

// File: rtl/dps_shadow_checker.sv
module dps_shadow_checker #(
  parameter int DATA_W = 32,
  parameter int SLOT_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              wr_ready,
  input logic [DATA_W-1:0] wr_data,
  input logic              dec_hit,
  input logic              dec_alias,
  input logic [SLOT_W-1:0] dec_slot,
  input logic              req_valid,
  input logic              req_ready,
  input logic [DATA_W-1:0] req_opt,
  input logic [DATA_W-1:0] req_src,
  input logic [DATA_W-1:0] req_cnt,
  input logic [DATA_W-1:0] req_dst,
  input logic [DATA_W-1:0] req_idx
);
  logic alias_wr;
  assign alias_wr = wr_en && dec_hit && dec_alias;

  assert_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    (!req_valid && wr_en && !(dec_hit && dec_alias)) |=> !req_valid);

  assert_launch_R4: assert property (@(posedge clk) disable iff (rst)
    (alias_wr && wr_ready) |=> req_valid);

  assert_bypass_opt_R4: assert property (@(posedge clk) disable iff (rst)
    (alias_wr && wr_ready && dec_slot == 0) |=> (req_opt == $past(wr_data)));

  assert_bypass_idx_R4: assert property (@(posedge clk) disable iff (rst)
    (alias_wr && wr_ready && dec_slot == 4) |=> (req_idx == $past(wr_data)));

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_opt) &&
      $stable(req_src) && $stable(req_cnt) && $stable(req_dst) && $stable(req_idx)));

  assert_drop_R7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !alias_wr) |=> !req_valid);

  assert_stall_R8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready && alias_wr) |-> !wr_ready);

  assert_plain_open_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !(dec_hit && dec_alias)) |-> wr_ready);
endmodule

bind dma_param_shadow dps_shadow_checker #(.DATA_W(DATA_W), .SLOT_W(SLOT_W)) u_chk (.*);

// File: tb/tb_dma_param_shadow.sv
module tb_dma_param_shadow;
  localparam logic [31:0] BASE = 32'h0200_0000;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst, wr_en, wr_ready, req_valid, req_ready;
  logic [31:0] wr_addr, wr_data;
  logic [3:0]  wr_be;
  logic [31:0] req_opt, req_src, req_cnt, req_dst, req_idx;

  int tests = 0;
  int fails = 0;
  logic [31:0] model [5];

  dma_param_shadow dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_be(wr_be), .wr_ready(wr_ready), .req_valid(req_valid), .req_ready(req_ready),
    .req_opt(req_opt), .req_src(req_src), .req_cnt(req_cnt), .req_dst(req_dst),
    .req_idx(req_idx)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // Bench-side address map: words 0..4 at base, alias at +0x20
  function automatic void model_store(input logic [31:0] a, input logic [31:0] d);
    int w;
    w = int'(a[4:2]);
    if (a[31:6] == BASE[31:6] && w < 5) model[w] = d;
  endfunction

  task automatic check_req(input string tag);
    chk({tag, " valid"}, {31'd0, req_valid}, 32'd1);
    chk({tag, " opt"}, req_opt, model[0]);
    chk({tag, " src"}, req_src, model[1]);
    chk({tag, " cnt"}, req_cnt, model[2]);
    chk({tag, " dst"}, req_dst, model[3]);
    chk({tag, " idx"}, req_idx, model[4]);
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; wr_be = be;
    @(negedge clk);
    wr_en = 1'b0;
    model_store(a, d);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : stim
    logic [31:0] held;
    rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0; wr_be = 4'hF; req_ready = 1'b1;
    for (int i = 0; i < 5; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", {31'd0, req_valid}, 32'd0);
    chk("R1 ready in reset", {31'd0, wr_ready}, 32'd1);
    rst = 1'b0;

    // R1/R4: first submit shows zeros except the written word
    wr(BASE + 32'h30, 32'hA5A5_0004, 4'hF);
    check_req("R1 R4 first submit");
    @(negedge clk);
    chk("R7 drop after accept", {31'd0, req_valid}, 32'd0);

    // R2 R3 R5: plain writes with narrow byte enables, then submit per slot
    for (int k = 0; k < 5; k++) begin
      wr(BASE + 32'(4 * k), 32'h1111_0000 * (k + 1) + 32'h00FF, 4'b0001 << (k % 4));
      chk("R3 plain no request", {31'd0, req_valid}, 32'd0);
      wr(BASE + 32'h20 + 32'(4 * k), 32'hC000_0000 | 32'(k * 32'h0101_0101), 4'b0010);
      check_req("R2 R4 R5 slot submit");
      @(negedge clk);
    end

    // R6: unmapped offsets in and outside the window
    for (int off = 20; off < 64; off += 4) begin
      if ((off >= 20 && off < 32) || off >= 52) begin
        wr(BASE + 32'(off), 32'hDEAD_BEEF, 4'hF);
        chk("R6 gap no request", {31'd0, req_valid}, 32'd0);
      end
    end
    wr(BASE + 32'h40, 32'hDEAD_0040, 4'hF);
    wr(32'h0300_0020, 32'hDEAD_0300, 4'hF);
    chk("R6 outside no request", {31'd0, req_valid}, 32'd0);
    wr(BASE + 32'h24, 32'h5555_1234, 4'hF);
    check_req("R6 bank untouched");
    @(negedge clk);

    // R7 R8: stall a submit behind a pending request
    req_ready = 1'b0;
    wr(BASE + 32'h20, 32'h0000_AAAA, 4'hF);
    check_req("R8 pending request");
    held = req_src;
    wr_en = 1'b1; wr_addr = BASE + 32'h24; wr_data = 32'h0000_BBBB;
    #1 chk("R8 submit stalled", {31'd0, wr_ready}, 32'd0);
    @(negedge clk);
    chk("R7 payload held", req_src, held);
    chk("R7 valid held", {31'd0, req_valid}, 32'd1);
    chk("R8 still stalled", {31'd0, wr_ready}, 32'd0);
    req_ready = 1'b1;
    #1 chk("R8 released", {31'd0, wr_ready}, 32'd1);
    @(negedge clk);
    wr_en = 1'b0;
    model_store(BASE + 32'h24, 32'h0000_BBBB);
    check_req("R8 stalled submit not dropped");

    // R7 R8: plain write during pending does not disturb the snapshot
    req_ready = 1'b0;
    @(negedge clk);
    held = req_cnt;
    wr_en = 1'b1; wr_addr = BASE + 32'h08; wr_data = 32'h0003_0010;
    #1 chk("R8 plain open while pending", {31'd0, wr_ready}, 32'd1);
    @(negedge clk);
    wr_en = 1'b0;
    model_store(BASE + 32'h08, 32'h0003_0010);
    chk("R7 snapshot kept", req_cnt, held);
    req_ready = 1'b1;
    @(negedge clk);
    chk("R7 drop", {31'd0, req_valid}, 32'd0);

    // R9: back-to-back submits, one per cycle
    wr_en = 1'b1;
    for (int i = 0; i < 5; i++) begin
      wr_addr = BASE + 32'h20 + 32'(4 * (4 - i));
      wr_data = 32'h9000_0000 + 32'(i);
      wr_be = 4'(i);
      @(negedge clk);
      model_store(wr_addr, wr_data);
      check_req("R9 back-to-back");
    end
    wr_en = 1'b0;
    @(negedge clk);
    chk("R9 idle after burst", {31'd0, req_valid}, 32'd0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule